// File: doc/BRIEF.md
# Banked UART Host Register File

This block is the processor-facing register file of a 16550-style serial port. The host reaches it through a 3-bit address with separate read and write strobes. It holds the eight-bit control registers and presents their contents as outputs to the rest of the port. Status that other logic produces comes in as plain inputs and is returned on reads: received data, interrupt status, line status and modem status.

One address has to serve several registers, so the value in the line control register chooses one of three banks. The general bank is the normal one. The divisor bank holds the two halves of the baud divisor. The enhanced bank holds a feature register and four flow-control character words. A read and a write to the same address can reach different registers. For example, address 0 in the general bank reads received data and writes transmit data, and the block then emits a one-cycle pulse to the receive path or to the transmit path. The line control register sits at address 3 in every bank, so software can always return to the general bank.

Read data is registered. It appears on `rdData` in the cycle after the read strobe and stays there until the next read.

Top module: `sio_reg_bank`

## Requirements
- R1: After reset, every exported register output reads 0x00, the 16-bit divisor reads 0x0000 and `rdData` is 0x00.
- R2: The general bank is active when line control bit 7 is 0. In that bank, address 1 (interrupt enable), address 4 (modem control) and address 7 (scratch) are read/write. Reads of address 2 return `intStatus`, reads of address 5 return `lineStatus` and reads of address 6 return `modemStatus`.
- R3: In the general bank, a read of address 0 returns `rxData` and raises `rxPop` for that strobe cycle only. A write to address 0 loads `thrOut` and raises `txLoad` for that cycle only. A write to address 2 loads `fcrOut`.
- R4: In the general bank, writes to address 5 or 6 change no register.
- R5: When line control bit 7 is 1 and the value is not 0xBF, address 0 is the low divisor byte (`divisorOut[7:0]`) and address 1 is the high divisor byte (`divisorOut[15:8]`). Neither pulse output fires in this bank.
- R6: When line control holds exactly 0xBF, the enhanced bank is active. Address 2 is the feature word, address 4 is Xon1, 5 is Xon2, 6 is Xoff1 and 7 is Xoff2. All five are read/write.
- R7: Address 3 reads and writes line control in every bank. The bank chosen for an access comes from the line control value held before that access.
- R8: An address that the active bank does not define reads as 0x00, and a write to it changes no register. These addresses are 2 and 4–7 in the divisor bank, and 0 and 1 in the enhanced bank.
- R9: A read strobe in cycle N puts the value on `rdData` after edge N. `rdData` holds that value until the next read strobe, even when writes happen in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| addr | input | 3 | Register address |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Registered read data |
| rxData | input | 8 | Head of the receive path |
| intStatus | input | 8 | Interrupt status byte |
| lineStatus | input | 8 | Line status byte |
| modemStatus | input | 8 | Modem status byte |
| rxPop | output | 1 | One-cycle receive read pulse |
| txLoad | output | 1 | One-cycle transmit load pulse |
| thrOut | output | 8 | Last transmit byte written |
| ierOut | output | 8 | Interrupt enable |
| fcrOut | output | 8 | FIFO control |
| lcrOut | output | 8 | Line control |
| mcrOut | output | 8 | Modem control |
| divisorOut | output | 16 | Baud divisor |
| featOut | output | 8 | Feature word |
| xon1Out | output | 8 | Xon character 1 |
| xon2Out | output | 8 | Xon character 2 |
| xoff1Out | output | 8 | Xoff character 1 |
| xoff2Out | output | 8 | Xoff character 2 |

## Verification
A wrong bank decision shows up in the edge right after the access:
- the wrong exported register changes, or
- a spurious `rxPop` or `txLoad` appears during the strobe cycle itself, or
- `rdData` in the next cycle carries a status input or a zero where the reference model expects a stored byte.

Every exported register is compared after every operation, so a corrupted write enable is caught one cycle after it acts. A stale read is caught as a hold violation on `rdData`.

The random mix pushes line control through 0xBF, through other values with bit 7 set and through values with bit 7 clear. This exercises every bank boundary, including a write that leaves a bank in the same cycle as a read from it.

// File: rtl/sio_reg_pkg.sv
package sio_reg_pkg;

  localparam int ADDR_W = 3;
  localparam int FLOW_N = 4;

  typedef enum logic [1:0] {
    BANK_GEN,
    BANK_DIV,
    BANK_ENH
  } bank_e;

  typedef enum logic [3:0] {
    SEL_ZERO,
    SEL_RHR,
    SEL_IER,
    SEL_ISR,
    SEL_LCR,
    SEL_MCR,
    SEL_LSR,
    SEL_MSR,
    SEL_SCR,
    SEL_DLL,
    SEL_DLM,
    SEL_EFR,
    SEL_FLOW0,
    SEL_FLOW1,
    SEL_FLOW2,
    SEL_FLOW3
  } rd_sel_e;

  typedef struct packed {
    logic              thrWr;
    logic              ierWr;
    logic              fcrWr;
    logic              lcrWr;
    logic              mcrWr;
    logic              scrWr;
    logic              dllWr;
    logic              dlmWr;
    logic              efrWr;
    logic [FLOW_N-1:0] flowWr;
    logic              rdLoad;
    rd_sel_e           rdSel;
    logic              rxPop;
    logic              txLoad;
  } strobe_t;

  function automatic bank_e bankOf(input logic [7:0] lcr, input logic [7:0] key,
                                   input int divBit);
    if (lcr == key)     return BANK_ENH;
    else if (lcr[divBit]) return BANK_DIV;
    else                return BANK_GEN;
  endfunction

endpackage

// File: rtl/sio_reg_ctrl.sv
module sio_reg_ctrl
  import sio_reg_pkg::*;
#(
  parameter int          DATA_W  = 8,
  parameter logic [7:0]  ENH_KEY = 8'hBF,
  parameter int          DIV_BIT = 7
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [DATA_W-1:0] lcrQ,
  output strobe_t           strobe
);

  bank_e bank;

  always_comb begin
    bank = bankOf(8'(lcrQ), ENH_KEY, DIV_BIT);
  end

  always_comb begin
    strobe        = '0;
    strobe.rdSel  = SEL_ZERO;
    strobe.rdLoad = rdEn;
    // line control is visible in every bank
    if (addr == 3'd3) begin
      strobe.lcrWr = wrEn;
      strobe.rdSel = SEL_LCR;
    end else begin
      unique case (bank)
        BANK_GEN: begin
          unique case (addr)
            3'd0: begin
              strobe.thrWr  = wrEn;
              strobe.txLoad = wrEn;
              strobe.rxPop  = rdEn;
              strobe.rdSel  = SEL_RHR;
            end
            3'd1: begin strobe.ierWr = wrEn; strobe.rdSel = SEL_IER; end
            3'd2: begin strobe.fcrWr = wrEn; strobe.rdSel = SEL_ISR; end
            3'd4: begin strobe.mcrWr = wrEn; strobe.rdSel = SEL_MCR; end
            3'd5: strobe.rdSel = SEL_LSR;
            3'd6: strobe.rdSel = SEL_MSR;
            3'd7: begin strobe.scrWr = wrEn; strobe.rdSel = SEL_SCR; end
            default: strobe.rdSel = SEL_ZERO;
          endcase
        end
        BANK_DIV: begin
          unique case (addr)
            3'd0: begin strobe.dllWr = wrEn; strobe.rdSel = SEL_DLL; end
            3'd1: begin strobe.dlmWr = wrEn; strobe.rdSel = SEL_DLM; end
            default: strobe.rdSel = SEL_ZERO;
          endcase
        end
        BANK_ENH: begin
          unique case (addr)
            3'd2: begin strobe.efrWr = wrEn; strobe.rdSel = SEL_EFR; end
            3'd4: begin strobe.flowWr[0] = wrEn; strobe.rdSel = SEL_FLOW0; end
            3'd5: begin strobe.flowWr[1] = wrEn; strobe.rdSel = SEL_FLOW1; end
            3'd6: begin strobe.flowWr[2] = wrEn; strobe.rdSel = SEL_FLOW2; end
            3'd7: begin strobe.flowWr[3] = wrEn; strobe.rdSel = SEL_FLOW3; end
            default: strobe.rdSel = SEL_ZERO;
          endcase
        end
        default: strobe.rdSel = SEL_ZERO;
      endcase
    end
  end

endmodule

// File: rtl/sio_reg_dp.sv
module sio_reg_dp
  import sio_reg_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] rxData,
  input  logic [DATA_W-1:0] intStatus,
  input  logic [DATA_W-1:0] lineStatus,
  input  logic [DATA_W-1:0] modemStatus,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] thrQ,
  output logic [DATA_W-1:0] ierQ,
  output logic [DATA_W-1:0] fcrQ,
  output logic [DATA_W-1:0] lcrQ,
  output logic [DATA_W-1:0] mcrQ,
  output logic [DATA_W-1:0] dllQ,
  output logic [DATA_W-1:0] dlmQ,
  output logic [DATA_W-1:0] efrQ,
  output logic [DATA_W-1:0] flowQ [FLOW_N]
);

  logic [DATA_W-1:0] scrQ;
  logic [DATA_W-1:0] rdNext;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      thrQ <= '0;
      ierQ <= '0;
      fcrQ <= '0;
      lcrQ <= '0;
      mcrQ <= '0;
      scrQ <= '0;
      dllQ <= '0;
      dlmQ <= '0;
      efrQ <= '0;
    end else begin
      if (strobe.thrWr) thrQ <= wrData;
      if (strobe.ierWr) ierQ <= wrData;
      if (strobe.fcrWr) fcrQ <= wrData;
      if (strobe.lcrWr) lcrQ <= wrData;
      if (strobe.mcrWr) mcrQ <= wrData;
      if (strobe.scrWr) scrQ <= wrData;
      if (strobe.dllWr) dllQ <= wrData;
      if (strobe.dlmWr) dlmQ <= wrData;
      if (strobe.efrWr) efrQ <= wrData;
    end
  end

  for (genvar g = 0; g < FLOW_N; g++) begin : g_flow
    always_ff @(posedge clk) begin
      if (!rstN)                 flowQ[g] <= '0;
      else if (strobe.flowWr[g]) flowQ[g] <= wrData;
    end
  end

  always_comb begin
    unique case (strobe.rdSel)
      SEL_RHR:   rdNext = rxData;
      SEL_IER:   rdNext = ierQ;
      SEL_ISR:   rdNext = intStatus;
      SEL_LCR:   rdNext = lcrQ;
      SEL_MCR:   rdNext = mcrQ;
      SEL_LSR:   rdNext = lineStatus;
      SEL_MSR:   rdNext = modemStatus;
      SEL_SCR:   rdNext = scrQ;
      SEL_DLL:   rdNext = dllQ;
      SEL_DLM:   rdNext = dlmQ;
      SEL_EFR:   rdNext = efrQ;
      SEL_FLOW0: rdNext = flowQ[0];
      SEL_FLOW1: rdNext = flowQ[1];
      SEL_FLOW2: rdNext = flowQ[2];
      SEL_FLOW3: rdNext = flowQ[3];
      default:   rdNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)              rdData <= '0;
    else if (strobe.rdLoad) rdData <= rdNext;
  end

  // R9: the read register moves only on a read strobe
  a_r9_rd_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.rdLoad |=> $stable(rdData));

  // R8: a write strobe reaches at most one register
  a_r8_single_target: assert property (@(posedge clk) disable iff (!rstN)
    $countones({strobe.thrWr, strobe.ierWr, strobe.fcrWr, strobe.lcrWr, strobe.mcrWr,
                strobe.scrWr, strobe.dllWr, strobe.dlmWr, strobe.efrWr, strobe.flowWr}) <= 1);

endmodule

// File: rtl/sio_reg_bank.sv
module sio_reg_bank
  import sio_reg_pkg::*;
#(
  parameter int         DATA_W  = 8,
  parameter logic [7:0] ENH_KEY = 8'hBF,
  parameter int         DIV_BIT = 7
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   addr,
  input  logic                wrEn,
  input  logic                rdEn,
  input  logic [DATA_W-1:0]   wrData,
  output logic [DATA_W-1:0]   rdData,
  input  logic [DATA_W-1:0]   rxData,
  input  logic [DATA_W-1:0]   intStatus,
  input  logic [DATA_W-1:0]   lineStatus,
  input  logic [DATA_W-1:0]   modemStatus,
  output logic                rxPop,
  output logic                txLoad,
  output logic [DATA_W-1:0]   thrOut,
  output logic [DATA_W-1:0]   ierOut,
  output logic [DATA_W-1:0]   fcrOut,
  output logic [DATA_W-1:0]   lcrOut,
  output logic [DATA_W-1:0]   mcrOut,
  output logic [2*DATA_W-1:0] divisorOut,
  output logic [DATA_W-1:0]   featOut,
  output logic [DATA_W-1:0]   xon1Out,
  output logic [DATA_W-1:0]   xon2Out,
  output logic [DATA_W-1:0]   xoff1Out,
  output logic [DATA_W-1:0]   xoff2Out
);

  strobe_t           strobe;
  logic [DATA_W-1:0] dllQ;
  logic [DATA_W-1:0] dlmQ;
  logic [DATA_W-1:0] flowQ [FLOW_N];

  sio_reg_ctrl #(.DATA_W(DATA_W), .ENH_KEY(ENH_KEY), .DIV_BIT(DIV_BIT)) ctrl_i (
    .addr   (addr),
    .wrEn   (wrEn),
    .rdEn   (rdEn),
    .lcrQ   (lcrOut),
    .strobe (strobe)
  );

  sio_reg_dp #(.DATA_W(DATA_W)) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .wrData      (wrData),
    .rxData      (rxData),
    .intStatus   (intStatus),
    .lineStatus  (lineStatus),
    .modemStatus (modemStatus),
    .rdData      (rdData),
    .thrQ        (thrOut),
    .ierQ        (ierOut),
    .fcrQ        (fcrOut),
    .lcrQ        (lcrOut),
    .mcrQ        (mcrOut),
    .dllQ        (dllQ),
    .dlmQ        (dlmQ),
    .efrQ        (featOut),
    .flowQ       (flowQ)
  );

  assign rxPop      = strobe.rxPop;
  assign txLoad     = strobe.txLoad;
  assign divisorOut = {dlmQ, dllQ};
  assign xon1Out    = flowQ[0];
  assign xon2Out    = flowQ[1];
  assign xoff1Out   = flowQ[2];
  assign xoff2Out   = flowQ[3];

  // R7: line control follows a write at address 3 whatever the bank
  a_r7_lcr_every_bank: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == 3'd3) |=> lcrOut == $past(wrData));

  // R4: read-only addresses of the general bank leave all state alone
  a_r4_ro_no_effect: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !lcrOut[DIV_BIT] && (addr == 3'd5 || addr == 3'd6)) |=>
      $stable({thrOut, ierOut, fcrOut, lcrOut, mcrOut, divisorOut,
               featOut, xon1Out, xon2Out, xoff1Out, xoff2Out}));

  // R5: pulses never fire outside the general bank
  a_r5_no_pulse_banked: assert property (@(posedge clk) disable iff (!rstN)
    lcrOut[DIV_BIT] |-> !rxPop && !txLoad);

  // R5: low divisor byte follows a write at address 0 in the divisor bank
  a_r5_div_low: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == 3'd0 && lcrOut[DIV_BIT] && lcrOut != ENH_KEY) |=>
      divisorOut[DATA_W-1:0] == $past(wrData));

  // R6: feature word follows a write at address 2 in the enhanced bank
  a_r6_feat_write: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == 3'd2 && lcrOut == ENH_KEY) |=> featOut == $past(wrData));

  // R3: a receive pulse needs a read strobe at address 0
  a_r3_pop_needs_read: assert property (@(posedge clk) disable iff (!rstN)
    rxPop |-> rdEn && addr == 3'd0);

endmodule

// File: tb/sio_reg_bank_tb_top.sv
`timescale 1ns/1ps
module sio_reg_bank_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] addr = '0;
  logic       wrEn = 1'b0, rdEn = 1'b0;
  logic [7:0] wrData = '0, rxData = '0, intStatus = '0, lineStatus = '0, modemStatus = '0;
  logic [7:0] rdData, thrOut, ierOut, fcrOut, lcrOut, mcrOut, featOut;
  logic [7:0] xon1Out, xon2Out, xoff1Out, xoff2Out;
  logic [15:0] divisorOut;
  logic       rxPop, txLoad;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  // reference model
  logic [7:0] mThr, mIer, mFcr, mLcr, mMcr, mScr, mDll, mDlm, mEfr, mRd;
  logic [7:0] mFlow [4];

  always #4 clk = ~clk;

  sio_reg_bank dut_i (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .rdEn(rdEn), .wrData(wrData),
    .rdData(rdData), .rxData(rxData), .intStatus(intStatus), .lineStatus(lineStatus),
    .modemStatus(modemStatus), .rxPop(rxPop), .txLoad(txLoad), .thrOut(thrOut),
    .ierOut(ierOut), .fcrOut(fcrOut), .lcrOut(lcrOut), .mcrOut(mcrOut),
    .divisorOut(divisorOut), .featOut(featOut), .xon1Out(xon1Out), .xon2Out(xon2Out),
    .xoff1Out(xoff1Out), .xoff2Out(xoff2Out)
  );

  task automatic check(input string req, input string what, input logic [15:0] act,
                       input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // 0 general, 1 divisor, 2 enhanced
  function automatic int bankM();
    if (mLcr == 8'hBF) return 2;
    else if (mLcr[7])  return 1;
    else               return 0;
  endfunction

  function automatic string reqFor(input int b, input logic [2:0] a);
    if (a == 3'd3) return "R7";
    if (b == 0)    return (a == 3'd0) ? "R3" : ((a == 3'd5 || a == 3'd6) ? "R4" : "R2");
    if (b == 1)    return (a <= 3'd1) ? "R5" : "R8";
    return (a <= 3'd1) ? "R8" : "R6";
  endfunction

  function automatic logic [7:0] expRead(input logic [2:0] a);
    int b = bankM();
    if (a == 3'd3) return mLcr;
    if (b == 0) begin
      case (a)
        3'd0: return rxData;
        3'd1: return mIer;
        3'd2: return intStatus;
        3'd4: return mMcr;
        3'd5: return lineStatus;
        3'd6: return modemStatus;
        default: return mScr;
      endcase
    end
    if (b == 1) return (a == 3'd0) ? mDll : ((a == 3'd1) ? mDlm : 8'h00);
    if (a == 3'd2) return mEfr;
    if (a >= 3'd4) return mFlow[a - 3'd4];
    return 8'h00;
  endfunction

  task automatic modelWrite(input logic [2:0] a, input logic [7:0] d);
    int b = bankM();
    if (a == 3'd3) mLcr = d;
    else if (b == 0) begin
      case (a)
        3'd0: mThr = d;
        3'd1: mIer = d;
        3'd2: mFcr = d;
        3'd4: mMcr = d;
        3'd7: mScr = d;
        default: ;
      endcase
    end else if (b == 1) begin
      if (a == 3'd0) mDll = d;
      if (a == 3'd1) mDlm = d;
    end else begin
      if (a == 3'd2) mEfr = d;
      if (a >= 3'd4) mFlow[a - 3'd4] = d;
    end
  endtask

  task automatic checkRegs(input string req);
    check(req, "thrOut", 16'(thrOut), 16'(mThr));
    check(req, "ierOut", 16'(ierOut), 16'(mIer));
    check(req, "fcrOut", 16'(fcrOut), 16'(mFcr));
    check(req, "lcrOut", 16'(lcrOut), 16'(mLcr));
    check(req, "mcrOut", 16'(mcrOut), 16'(mMcr));
    check(req, "divisorOut", divisorOut, {mDlm, mDll});
    check(req, "featOut", 16'(featOut), 16'(mEfr));
    check(req, "xon1Out", 16'(xon1Out), 16'(mFlow[0]));
    check(req, "xon2Out", 16'(xon2Out), 16'(mFlow[1]));
    check(req, "xoff1Out", 16'(xoff1Out), 16'(mFlow[2]));
    check(req, "xoff2Out", 16'(xoff2Out), 16'(mFlow[3]));
  endtask

  task automatic doOp(input bit rd, input bit wr, input logic [2:0] a, input logic [7:0] d);
    string req;
    logic [7:0] expRd;
    bit gen0;
    @(negedge clk);
    rxData = 8'($urandom); intStatus = 8'($urandom);
    lineStatus = 8'($urandom); modemStatus = 8'($urandom);
    addr = a; wrData = d; rdEn = rd; wrEn = wr;
    req = reqFor(bankM(), a);
    gen0 = (bankM() == 0) && (a == 3'd0);
    expRd = rd ? expRead(a) : mRd;
    #2;
    check((gen0 || !rd) ? "R3" : "R5", "rxPop", 16'(rxPop), 16'(rd && gen0));
    check((gen0 || !wr) ? "R3" : "R5", "txLoad", 16'(txLoad), 16'(wr && gen0));
    @(negedge clk);
    rdEn = 1'b0; wrEn = 1'b0;
    if (wr) modelWrite(a, d);
    mRd = expRd;
    check(rd ? req : "R9", "rdData", 16'(rdData), 16'(mRd));
    checkRegs(wr ? req : "R9");
  endtask

  initial begin
    mThr = 0; mIer = 0; mFcr = 0; mLcr = 0; mMcr = 0; mScr = 0;
    mDll = 0; mDlm = 0; mEfr = 0; mRd = 0;
    for (int i = 0; i < 4; i++) mFlow[i] = 0;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    check("R1", "rdData", 16'(rdData), 16'h0);
    checkRegs("R1");
    check("R1", "rxPop", 16'(rxPop), 16'h0);

    // directed: general bank
    doOp(0, 1, 3'd7, 8'h5A);
    doOp(1, 0, 3'd7, 8'h00);
    doOp(1, 1, 3'd0, 8'hC3);        // R3 read and write together
    doOp(0, 1, 3'd5, 8'hFF);        // R4
    doOp(0, 1, 3'd6, 8'hEE);        // R4
    doOp(1, 0, 3'd5, 8'h00);
    // divisor bank
    doOp(0, 1, 3'd3, 8'h83);
    doOp(1, 1, 3'd0, 8'h34);        // R5 no pulse
    doOp(0, 1, 3'd1, 8'h12);
    doOp(1, 0, 3'd1, 8'h00);
    doOp(1, 1, 3'd2, 8'h77);        // R8 undefined
    doOp(1, 1, 3'd6, 8'h77);
    // enhanced bank
    doOp(0, 1, 3'd3, 8'hBF);
    for (int a = 4; a < 8; a++) doOp(0, 1, 3'(a), 8'(8'h10 + a));
    doOp(0, 1, 3'd2, 8'hA5);
    doOp(1, 1, 3'd0, 8'h99);        // R8 undefined in enhanced bank
    doOp(1, 1, 3'd1, 8'h98);
    doOp(1, 0, 3'd6, 8'h00);
    doOp(1, 1, 3'd3, 8'h00);        // R7 leave bank while reading line control
    doOp(1, 0, 3'd2, 8'h00);

    // constrained random
    for (int n = 0; n < 4000; n++) begin
      int sel = int'($urandom_range(0, 9));
      logic [7:0] d = 8'($urandom);
      logic [2:0] a = 3'($urandom);
      if (sel == 0) begin
        int k = int'($urandom_range(0, 3));
        d = (k == 0) ? 8'hBF : (k == 1) ? (d | 8'h80) : (k == 2) ? (d & 8'h7F) : d;
        a = 3'd3;
      end
      doOp(sel != 1 && $urandom_range(0, 1) == 1, sel != 2 && $urandom_range(0, 2) != 0, a, d);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule